// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial-bus slave that gives a host controller access to a small configuration register file of three bytes. The host selects a byte with a command byte and can then move one byte or two consecutive bytes in either direction. For a read, the host sends the command in a write phase and then issues a repeated start with the read bit set. The slave address is fixed except for its two lowest bits, which come from strap pins. This lets several copies of the block share one bus.

The first byte holds a three-bit frequency multiplier code and four output-enable bits. The second byte holds a vendor test enable. The third byte is a read-only identification byte. The decoded fields are presented as registered outputs to a mode controller.

The block runs on a system clock derived from the reference clock, which is much faster than the bus clock. It oversamples both bus lines through synchronizer chains. It never stretches the clock. It drives the data line as an open-drain pull-down only.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The 7-bit address is sent MSB first and equals 1,1,0,1,1 followed by strap_id[1] and strap_id[0]. An eighth bit follows: 0 selects write and 1 selects read. The slave acknowledges only a matching address and otherwise stays silent until the next start.
- R2: In the command byte, bit 7 must be 1 and bits 6:0 give the byte offset, which must be 0, 1 or 2. Any other command byte is not acknowledged and leaves every register unchanged.
- R3: A byte write sets the addressed byte to the data byte, and the slave acknowledges each byte. The sequence is: start, address+W, command, data, stop.
- R4: A byte read returns the addressed byte. The sequence is: start, address+W, command, repeated start, address+R, then one byte, after which the master sends NACK and stop.
- R5: In a word write at offset N, the first data byte goes to byte N and the second to byte N+1. A data byte aimed at an offset above 2 is not acknowledged.
- R6: In a word read at offset N, the slave returns byte N and then byte N+1. The master acknowledges the first byte and not the second.
- R7: After reset, byte 0 is 0x1F and byte 1 is 0x00. The outputs are then mult_code_o=001, out_en_o=1111 and test_en_o=0.
- R8: Byte 2 always reads 0x03. Its bits 7:3 hold the revision, which is 0, and its bits 2:0 hold the vendor code 011. Writes to byte 2 are acknowledged but have no effect.
- R9: The outputs come from the register bits as follows. mult_code_o is byte 0 bits 6:4. out_en_o[3:0] is byte 0 bits 3:0. test_en_o is byte 1 bit 0.
- R10: sda_pull_o high means the data line is pulled low. It is low during and right after reset. It never starts pulling while SCL is high.
- R11: A start or repeated start is recognised in any state. A stop in any state returns the slave to idle, and a later transfer then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock derived from the reference clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_id | input | 2 | Strap pins forming the two low address bits |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain) |
| mult_code_o | output | 3 | Multiplier code from byte 0 |
| out_en_o | output | 4 | Output enables from byte 0 |
| test_en_o | output | 1 | Vendor test enable from byte 1 |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two. This places the acknowledge and read-data edges closer to the bus quarter period of eight clocks, so it shows that the pull-down is settled before SCL rises even with the deeper chain. The address stays at its default upper bits. The bench moves the strap pins during the run, so the match and mismatch cases cover both strap values. Word transfers at offsets 0, 1 and 2 reach both neighbours of each byte and the offset past the end of the file.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_CMD,
    ST_WDATA,
    ST_LOAD,
    ST_RDATA,
    ST_RACK
  } smb_state_e;

  typedef enum logic [1:0] {
    NXT_CMD,
    NXT_WDATA,
    NXT_LOAD
  } ack_next_e;

  // Power-on contents of the writable bytes
  function automatic logic [7:0] cfg_reset_byte(input int idx);
    return (idx == 0) ? 8'h1F : 8'h00;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] line_in;
  logic [1:0] line_out;
  logic       scl_q;
  logic       sda_q;

  assign line_in = {sda_i, scl_i};

  genvar l;
  generate
    for (l = 0; l < 2; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], line_in[l]};
      end
      assign line_out[l] = chain[STAGES-1];
    end
  endgenerate

  assign scl_s = line_out[0];
  assign sda_s = line_out[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import cfgs_pkg::*;
#(
  parameter int          NUM_BYTES = 3,
  parameter int          RW_BYTES  = 2,
  parameter int          OFFS_W    = 7,
  parameter logic [7:0]  RO_VALUE  = 8'h03
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [OFFS_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [OFFS_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic [RW_BYTES*8-1:0] rw_flat
);

  logic [7:0] byte_q [NUM_BYTES];

  genvar g;
  generate
    for (g = 0; g < NUM_BYTES; g++) begin : g_byte
      if (g < RW_BYTES) begin : g_rw
        always_ff @(posedge clk) begin
          if (rst)
            byte_q[g] <= cfg_reset_byte(g);
          else if (wr_en && wr_addr == OFFS_W'(g))
            byte_q[g] <= wr_data;
        end
        assign rw_flat[g*8 +: 8] = byte_q[g];
      end else begin : g_ro
        assign byte_q[g] = RO_VALUE;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      if (rd_addr == OFFS_W'(i)) rd_data = byte_q[i];
  end

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import cfgs_pkg::*;
#(
  parameter int                ADDR_HI_W = 5,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b11011,
  parameter int                ID_W      = 2,
  parameter int                OFFS_W    = 7,
  parameter int                NUM_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ID_W-1:0]   strap_id,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [OFFS_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [OFFS_W-1:0] ptr,
  output logic              sda_pull_o
);

  localparam logic [OFFS_W-1:0] LAST_OFF = OFFS_W'(NUM_BYTES - 1);

  smb_state_e  state;
  ack_next_e   ret;
  logic [7:0]  rx_sr;
  logic [7:0]  tx_sr;
  logic [2:0]  bcnt;
  logic        full;
  logic        mack;
  logic        addr_hit;

  assign addr_hit = (rx_sr[7:1] == {ADDR_HI, strap_id});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ret        <= NXT_CMD;
      rx_sr      <= '0;
      tx_sr      <= '0;
      bcnt       <= '0;
      full       <= 1'b0;
      mack       <= 1'b1;
      ptr        <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      sda_pull_o <= (state == ST_ACK) || (state == ST_RDATA && !tx_sr[7]);
      if (start_det) begin
        state <= ST_ADDR;
        bcnt  <= '0;
        full  <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        full  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && !full) begin
              rx_sr <= {rx_sr[6:0], sda_s};
              bcnt  <= bcnt + 3'd1;
              if (bcnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              bcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state <= ST_ACK;
                  ret   <= rx_sr[0] ? NXT_LOAD : NXT_CMD;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                if (rx_sr[7] && rx_sr[6:0] <= LAST_OFF) begin
                  ptr   <= rx_sr[OFFS_W-1:0];
                  state <= ST_ACK;
                  ret   <= NXT_WDATA;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                if (ptr <= LAST_OFF) begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_sr;
                  ptr     <= ptr + OFFS_W'(1);
                  state   <= ST_ACK;
                  ret     <= NXT_WDATA;
                end else begin
                  state <= ST_IDLE;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              case (ret)
                NXT_LOAD: state <= ST_LOAD;
                NXT_CMD:  state <= ST_CMD;
                default:  state <= ST_WDATA;
              endcase
            end
          end
          ST_LOAD: begin
            tx_sr <= rd_data;
            bcnt  <= '0;
            state <= ST_RDATA;
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bcnt == 3'd7) begin
                state <= ST_RACK;
              end else begin
                tx_sr <= {tx_sr[6:0], 1'b1};
                bcnt  <= bcnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= sda_s;
            if (scl_fall) begin
              if (!mack) begin
                ptr   <= ptr + OFFS_W'(1);
                state <= ST_LOAD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b11011,
  parameter int         NUM_BYTES   = 3,
  parameter int         RW_BYTES    = 2,
  parameter logic [7:0] RO_VALUE    = 8'h03
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_id,
  output logic       sda_pull_o,
  output logic [2:0] mult_code_o,
  output logic [3:0] out_en_o,
  output logic       test_en_o
);

  localparam int OFFS_W = 7;

  logic                  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                  wr_en;
  logic [OFFS_W-1:0]     wr_addr, ptr;
  logic [7:0]            wr_data, rd_data;
  logic [RW_BYTES*8-1:0] rw_flat;
  logic                  unused_bits;

  smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_proto_fsm #(
    .ADDR_HI_W(5), .ADDR_HI(ADDR_HI), .ID_W(2), .OFFS_W(OFFS_W), .NUM_BYTES(NUM_BYTES)
  ) fsm_i (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .strap_id(strap_id), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr), .sda_pull_o(sda_pull_o)
  );

  smb_cfg_regs #(
    .NUM_BYTES(NUM_BYTES), .RW_BYTES(RW_BYTES), .OFFS_W(OFFS_W), .RO_VALUE(RO_VALUE)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .rw_flat(rw_flat)
  );

  assign mult_code_o = rw_flat[6:4];
  assign out_en_o    = rw_flat[3:0];
  assign test_en_o   = rw_flat[8];
  assign unused_bits = ^{rw_flat[RW_BYTES*8-1:9], rw_flat[7]};

endmodule

// File: rtl/cfg_smbus_slave_chk.sv
module cfg_smbus_slave_chk #(
  parameter int OFFS_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_pull_o,
  input logic              wr_en,
  input logic [OFFS_W-1:0] wr_addr,
  input logic [2:0]        mult_code_o,
  input logic [3:0]        out_en_o,
  input logic              test_en_o
);

  // R7: reset values appear on the decoded outputs
  assert_reset_values_R7: assert property (@(posedge clk)
    rst |=> (mult_code_o == 3'b001 && out_en_o == 4'b1111 && !test_en_o));

  // R10: line released after reset
  assert_pull_released_R10: assert property (@(posedge clk)
    rst |=> !sda_pull_o);

  // R10: pull-down never begins while SCL is high
  assert_no_pull_on_high_R10: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> !$rose(sda_pull_o));

  // R2: outputs change only after a committed data write
  assert_no_change_without_write_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(mult_code_o) && $stable(out_en_o) && $stable(test_en_o)));

  // R8: a write to the read-only byte leaves the outputs alone
  assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFFS_W'(2)) |=>
      ($stable(mult_code_o) && $stable(out_en_o) && $stable(test_en_o)));

endmodule

bind cfg_smbus_slave cfg_smbus_slave_chk #(.OFFS_W(7)) chk_i (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull_o(sda_pull_o), .wr_en(wr_en),
  .wr_addr(wr_addr), .mult_code_o(mult_code_o), .out_en_o(out_en_o), .test_en_o(test_en_o)
);

// File: tb/cfg_smbus_slave_tb_top.sv
module cfg_smbus_slave_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       sda_pull;
  logic [2:0] mult;
  logic [3:0] en;
  logic       test_en;
  logic       sda_line;
  logic       done = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got;
  event       got_ev;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  cfg_smbus_slave #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_id(strap),
    .sda_pull_o(sda_pull), .mult_code_o(mult), .out_en_o(en), .test_en_o(test_en)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q();
      scl_m = 1'b1; q();
      scl_m = 1'b0;
    end
    q();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    acked = !sda_line;
    scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      scl_m = 1'b1; q();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    q();
    sda_m = ack ? 1'b0 : 1'b1; q();
    scl_m = 1'b1; q();
    scl_m = 1'b0; q();
  endtask

  // acks: [0] address, [1] command, [2] first data, [3] second data
  task automatic smb_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d0,
                           input logic [7:0] d1, input int nb, output logic [3:0] acks);
    logic k;
    acks = '0;
    bus_start();
    send_byte({a, 1'b0}, k); acks[0] = k;
    send_byte(cmd, k);       acks[1] = k;
    if (nb > 0) begin send_byte(d0, k); acks[2] = k; end
    if (nb > 1) begin send_byte(d1, k); acks[3] = k; end
    bus_stop();
  endtask

  // driver: pushes expected bytes into the scoreboard, then reads them
  task automatic smb_read(input logic [6:0] a, input logic [7:0] cmd, input int nb,
                          input logic [7:0] e0, input logic [7:0] e1, input string tag);
    logic k0, k1, k2;
    logic [7:0] b;
    exp_q.push_back(e0); tag_q.push_back({tag, " byte0"});
    if (nb > 1) begin exp_q.push_back(e1); tag_q.push_back({tag, " byte1"}); end
    bus_start();
    send_byte({a, 1'b0}, k0);
    send_byte(cmd, k1);
    bus_start();
    send_byte({a, 1'b1}, k2);
    chk({29'd0, k0, k1, k2}, 32'h7, {tag, " R4 acks during read setup"});
    for (int i = 0; i < nb; i++) begin
      recv_byte(i < nb - 1, b);
      got = b;
      ->got_ev;
    end
    bus_stop();
  endtask

  // monitor: pops and compares each byte as it arrives
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        chk({24'd0, got}, 32'hDEAD, "unexpected read byte");
      end else begin
        chk({24'd0, got}, {24'd0, exp_q.pop_front()}, tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  localparam logic [6:0] A01 = 7'b1101101;
  localparam logic [6:0] A10 = 7'b1101110;

  initial begin
    logic [3:0] acks;
    logic       k;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    q();

    // R7 / R10: reset state
    chk({29'd0, mult}, 32'h1, "R7 mult after reset");
    chk({28'd0, en}, 32'hF, "R7 enables after reset");
    chk({31'd0, test_en}, 32'h0, "R7 test enable after reset");
    chk({31'd0, sda_pull}, 32'h0, "R10 line released after reset");

    // R4 / R7 / R8: single-byte reads of all bytes
    smb_read(A01, 8'h80, 1, 8'h1F, 8'h00, "R4 R7 read byte0");
    smb_read(A01, 8'h81, 1, 8'h00, 8'h00, "R4 R7 read byte1");
    smb_read(A01, 8'h82, 1, 8'h03, 8'h00, "R8 read byte2");

    // R3 / R9: byte write
    smb_write(A01, 8'h80, 8'h5A, 8'h00, 1, acks);
    chk({28'd0, acks}, 32'h7, "R3 byte write acks");
    chk({29'd0, mult}, 32'h5, "R9 mult from byte0[6:4]");
    chk({28'd0, en}, 32'hA, "R9 enables from byte0[3:0]");
    smb_read(A01, 8'h80, 1, 8'h5A, 8'h00, "R3 read back byte0");

    // R5 / R6 / R9: word write then word read at offset 0
    smb_write(A01, 8'h80, 8'h37, 8'h81, 2, acks);
    chk({28'd0, acks}, 32'hF, "R5 word write acks");
    chk({29'd0, mult}, 32'h3, "R5 low byte to byte0 mult");
    chk({28'd0, en}, 32'h7, "R5 low byte to byte0 enables");
    chk({31'd0, test_en}, 32'h1, "R9 test enable from byte1[0]");
    smb_read(A01, 8'h80, 2, 8'h37, 8'h81, "R6 word read off0");

    // R8: write to read-only byte
    smb_write(A01, 8'h82, 8'hFF, 8'h00, 1, acks);
    chk({28'd0, acks}, 32'h7, "R8 write to byte2 acked");
    smb_read(A01, 8'h82, 1, 8'h03, 8'h00, "R8 byte2 unchanged");
    chk({28'd0, en}, 32'h7, "R8 enables unchanged");

    // R1: address mismatch
    smb_write(A10, 8'h80, 8'h00, 8'h00, 1, acks);
    chk({31'd0, acks[0]}, 32'h0, "R1 wrong address not acked");
    chk({28'd0, en}, 32'h7, "R1 no change on wrong address");

    // R2: bad command bytes
    smb_write(A01, 8'h00, 8'h00, 8'h00, 1, acks);
    chk({30'd0, acks[1:0]}, 32'h1, "R2 cmd bit7 clear not acked");
    smb_write(A01, 8'h83, 8'h00, 8'h00, 1, acks);
    chk({30'd0, acks[1:0]}, 32'h1, "R2 offset 3 not acked");
    smb_read(A01, 8'h80, 1, 8'h37, 8'h00, "R2 byte0 unchanged");

    // R6 / R8: word read at offset 1
    smb_read(A01, 8'h81, 2, 8'h81, 8'h03, "R6 word read off1");

    // R1: strap change moves the address
    strap = 2'b10;
    q();
    smb_write(A10, 8'h81, 8'h00, 8'h00, 1, acks);
    chk({28'd0, acks}, 32'h7, "R1 new strap address acked");
    chk({31'd0, test_en}, 32'h0, "R1 write via new address");
    smb_write(A01, 8'h81, 8'h01, 8'h00, 1, acks);
    chk({31'd0, acks[0]}, 32'h0, "R1 old address now ignored");
    chk({31'd0, test_en}, 32'h0, "R1 old address no effect");

    // R5: word write running past the last byte
    smb_write(A10, 8'h82, 8'h11, 8'h22, 2, acks);
    chk({28'd0, acks}, 32'h7, "R5 second byte past end not acked");

    // R11: stop in the middle of a transfer, then a normal one
    bus_start();
    send_byte({A10, 1'b0}, k);
    chk({31'd0, k}, 32'h1, "R11 address acked before abort");
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q(); q();
    smb_read(A10, 8'h80, 1, 8'h37, 8'h00, "R11 read after abort");
    chk({31'd0, sda_pull}, 32'h0, "R10 line released when idle");

    q(); q();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule